// File: doc/BRIEF.md
# Handshaked MSB-First Serial Transmitter

This block takes one byte at a time from a producer and puts it on a single serial line as an asynchronous frame. The producer presents the byte and raises a request. The block answers by raising acknowledge. It then sends the whole frame while acknowledge stays high, and it lowers acknowledge when the last data bit has gone out. The producer drops its request once it has seen acknowledge. The block's clock is assumed to already tick once per bit time, so each register update moves the line on by one bit.

A frame begins with one low start bit. Eight data bits follow, most significant first. The line then returns high, which gives the stop bit and the idle level. A new transfer starts only after the request has been observed low. As a result, a request held high cannot start a second frame, and each frame is followed by at least one high bit time.

Top module: `hs_serial_tx`

## Requirements
- R1: While reset is asserted, and after it is released with no transfer running, `ack_o` is 0 and `line_o` is 1 (idle/mark level).
- R2: When `req_i` is 1, `ack_o` is 0 and the request has been seen low since the last start, `ack_o` rises at the next clock edge. During the first bit time after that edge, `line_o` is 0 (start bit).
- R3: During the 8 bit times after the start bit, `line_o` carries the captured byte from bit 7 down to bit 0, one bit per clock.
- R4: `ack_o` stays high for exactly 9 clock cycles (start bit plus 8 data bits). It then falls and `line_o` returns to 1 (stop bit).
- R5: The byte is captured on the edge where `ack_o` rises. Changes on `data_i` after that edge do not alter the frame.
- R6: If `req_i` stays high after a frame ends, no new frame starts. `ack_o` stays 0 and `line_o` stays 1 until `req_i` has been 0 for at least one cycle.
- R7: If `req_i` is lowered during a frame and raised again in the stop-bit cycle, the next start bit follows after exactly one high bit time, so consecutive frames are 10 bit times apart.
- R8: A synchronous reset asserted in the middle of a frame forces `ack_o` low and `line_o` high at the next edge. The next transfer after reset then produces a complete, correct frame.
- R9: Out of reset, the request must be seen low before the first transfer. A `req_i` that is already high when reset is released is ignored until it has gone low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Producer request, four-phase |
| data_i | input | DATA_W (8) | Byte to send; held stable from request until acknowledge |
| ack_o | output | 1 | Acknowledge; high while the frame's start and data bits are sent |
| line_o | output | 1 | Serial output line, idles high |

## Verification
The bench builds the block with its default width of DATA_W = 8. That width brings every case within reach: the full 8-bit frame, the 4-bit counter reaching its terminal value of 8, and the all-zero and all-one bytes, where a shifting or ordering mistake cannot hide behind alternating bits. At this width the line is decoded one bit per clock against each table byte. Directed tests then cover a held request, back-to-back frames with a one-bit gap, a request that is already high when reset is released, and a reset in the middle of a frame.

// File: rtl/hstx_pkg.sv
package hstx_pkg;

    // Line levels of the asynchronous frame.
    localparam logic LINE_MARK  = 1'b1;
    localparam logic LINE_SPACE = 1'b0;

    // Handshake controller state.
    typedef struct packed {
        logic ack;    // transfer in progress
        logic armed;  // request has been seen low since the last start
    } hs_state_t;

endpackage

// File: rtl/hstx_handshake.sv
module hstx_handshake
    import hstx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic last_bit,
    output logic ack,
    output logic start
);

    hs_state_t st_d, st_q;
    logic      start_d;

    always_comb begin
        st_d    = st_q;
        start_d = req && !st_q.ack && st_q.armed;
        if (start_d) begin
            st_d.ack   = 1'b1;
            st_d.armed = 1'b0;
        end else begin
            if (st_q.ack && last_bit) begin
                st_d.ack = 1'b0;
            end
            if (!req) begin
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ack: 1'b0, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ack   = st_q.ack;
    assign start = start_d;

endmodule

// File: rtl/hstx_bitcount.sv
module hstx_bitcount #(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    output logic first_slot,
    output logic last_bit
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (start) begin
            cs_d.cnt = '0;
        end else if (active && cs_q.cnt != LAST) begin
            cs_d.cnt = cs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= '{cnt: '0};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign first_slot = (cs_q.cnt == '0);
    assign last_bit   = (cs_q.cnt == LAST);

endmodule

// File: rtl/hstx_shifter.sv
module hstx_shifter
    import hstx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    input  logic              first_slot,
    input  logic [DATA_W-1:0] din,
    output logic              line
);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
    } sh_state_t;

    sh_state_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (start) begin
            sh_d.sr = din;
        end else if (active && !first_slot) begin
            sh_d.sr = {sh_q.sr[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '{sr: '0};
        end else begin
            sh_q <= sh_d;
        end
    end

    always_comb begin
        if (!active) begin
            line = LINE_MARK;
        end else if (first_slot) begin
            line = LINE_SPACE;
        end else begin
            line = sh_q.sr[DATA_W-1];
        end
    end

endmodule

// File: rtl/hs_serial_tx.sv
module hs_serial_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ack_o,
    output logic              line_o
);

    logic start;
    logic active;
    logic first_slot;
    logic last_bit;

    hstx_handshake u_hs (
        .clk      (clk),
        .rst      (rst),
        .req      (req_i),
        .last_bit (last_bit),
        .ack      (active),
        .start    (start)
    );

    hstx_bitcount #(.DATA_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .active     (active),
        .first_slot (first_slot),
        .last_bit   (last_bit)
    );

    hstx_shifter #(.DATA_W(DATA_W)) u_sh (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .active     (active),
        .first_slot (first_slot),
        .din        (data_i),
        .line       (line_o)
    );

    assign ack_o = active;

endmodule

// File: rtl/hs_serial_tx_checker.sv
module hs_serial_tx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic [DATA_W-1:0] data,
    input logic              ack,
    input logic              line
);

    localparam int RUN_W = $clog2(DATA_W + 3);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !ack) begin
            run_q <= '0;
        end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !ack |-> line) else $error("idle line not high"); // R1

    AST_START_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) && !$past(rst) |-> $past(req) && !line) else $error("bad start"); // R2

    AST_FIRST_BIT_MSB: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) && !$past(rst) |=> line == $past(data[DATA_W-1], 2)) else $error("msb wrong"); // R3

    AST_ACK_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) && !$past(rst) |-> run_q == RUN_W'(DATA_W + 1)) else $error("ack length"); // R4

    AST_ACK_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(DATA_W + 1)) else $error("ack too long"); // R4

endmodule

bind hs_serial_tx hs_serial_tx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .req  (req_i),
    .data (data_i),
    .ack  (ack_o),
    .line (line_o)
);

// File: tb/tb_hs_serial_tx.sv
module tb_hs_serial_tx;

    localparam int DATA_W = 8;
    localparam int NVEC   = 6;
    localparam logic [DATA_W-1:0] VEC [NVEC] =
        '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h6E};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic [DATA_W-1:0] data = '0;
    logic              ack;
    logic              line;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hs_serial_tx #(.DATA_W(DATA_W)) dut (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .data_i (data),
        .ack_o  (ack),
        .line_o (line)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Called at a negedge where req/data were just set high; checks a full frame.
    // Returns at the negedge of the stop-bit cycle.
    task automatic run_frame(input logic [DATA_W-1:0] b, input bit keep_req, input bit scramble);
        @(negedge clk);
        chk(ack == 1'b1, "R2 ack rise", int'(ack), 1);
        chk(line == 1'b0, "R2 start bit", int'(line), 0);
        if (!keep_req) req = 1'b0;
        for (int k = 1; k <= DATA_W; k++) begin
            @(negedge clk);
            if (k == 1 && scramble) data = ~b;
            chk(line == b[DATA_W-k], "R3 data bit", int'(line), int'(b[DATA_W-k]));
            chk(ack == 1'b1, "R4 ack held", int'(ack), 1);
        end
        @(negedge clk);
        chk(ack == 1'b0, "R4 ack fall", int'(ack), 0);
        chk(line == 1'b1, "R4 stop bit", int'(line), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ack == 1'b0, "R1 reset ack", int'(ack), 0);
        chk(line == 1'b1, "R1 reset line", int'(line), 1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(ack == 1'b0 && line == 1'b1, "R1 idle", int'({ack, line}), 1);

        // Table walk; data scrambled after capture on odd entries (R5).
        for (int i = 0; i < NVEC; i++) begin
            req  = 1'b1;
            data = VEC[i];
            run_frame(VEC[i], 1'b0, (i % 2) == 1);
            repeat (2) @(negedge clk);
        end

        // R7: back-to-back frames, one stop bit between them.
        req = 1'b1; data = 8'hC6;
        run_frame(8'hC6, 1'b0, 1'b0);
        req = 1'b1; data = 8'h39;
        run_frame(8'h39, 1'b0, 1'b0);
        repeat (2) @(negedge clk);

        // R6: request held high after the frame does not restart.
        req = 1'b1; data = 8'h5B;
        run_frame(8'h5B, 1'b1, 1'b0);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(ack == 1'b0 && line == 1'b1, "R6 held req no restart", int'({ack, line}), 1);
        end
        req = 1'b0;
        @(negedge clk);
        req = 1'b1; data = 8'h96;
        run_frame(8'h96, 1'b0, 1'b0);
        repeat (2) @(negedge clk);

        // R9: request already high when reset is released.
        rst = 1'b1; req = 1'b1; data = 8'hE7;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(ack == 1'b0 && line == 1'b1, "R9 req before low ignored", int'({ack, line}), 1);
        end
        req = 1'b0;
        @(negedge clk);
        req = 1'b1;
        run_frame(8'hE7, 1'b0, 1'b0);
        repeat (2) @(negedge clk);

        // R8: reset in the middle of a frame.
        req = 1'b1; data = 8'h0F;
        repeat (5) @(negedge clk);
        req = 1'b0;
        chk(ack == 1'b1, "R8 frame running", int'(ack), 1);
        rst = 1'b1;
        @(negedge clk);
        chk(ack == 1'b0 && line == 1'b1, "R8 reset mid-frame", int'({ack, line}), 1);
        rst = 1'b0;
        @(negedge clk);
        req = 1'b1; data = 8'hC3;
        run_frame(8'hC3, 1'b0, 1'b0);
        repeat (2) @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule